// File: doc/BRIEF.md
# Nonvolatile Word Array Request Controller

This block gives outside logic a plain parallel port onto a small on-chip nonvolatile word array. A requester picks one of three operations (read, program or sector erase) by pulling its active-low strobe low, with the word address and, for a program, the data word presented alongside. The block accepts the request on the strobe's falling edge, drops its active-low busy flag for the whole operation, and raises it again once the array is ready for the next request. After a read, a valid flag goes high and the data-out bus holds the word just read.

The array and its slow access times are modelled inside the block: a register array with separate, parameterised cycle counts for read, program and erase. As in real floating-gate storage, a program can only clear bits, and an erase returns every word of a sector to all ones. Only single-word accesses exist. Conflicting strobes are rejected outright, and a read-only build parameter turns the block into a read port that ignores program and erase requests. The oscillator-enable output stays asserted at all times.

The sequencer has four states: `ST_IDLE`, `ST_READ`, `ST_PROG` and `ST_ERASE`. Transitions: *accept-read*, *accept-prog* and *accept-erase* (idle to the operation state, on a legal strobe fall), *count* (stay in the operation state while the cycle counter is non-zero) and *finish* (operation state back to idle once the counter reaches zero, which performs the array action).

Top module: `nvm_par_ctrl`

## Requirements
- R1: Strobes `rd_req_n` (read), `wr_req_n` (program) and `er_req_n` (erase) are active low. A request is taken only on a clock where its strobe is low after being high on the previous clock. A strobe held low after the operation completes never starts it again.
- R2: `busy_n` goes low on the clock edge that accepts a request and stays low for exactly `READ_CYC`, `PROG_CYC` or `ERASE_CYC` clocks, then returns high. A strobe falling while `busy_n` is low is ignored and is not remembered.
- R3: When a read completes, `rd_valid` goes high and `rdata` holds the word stored at the read address. `rd_valid` stays high until the next accepted request, which clears it on the same edge that pulls `busy_n` low.
- R4: A program sets the addressed word to its old value AND `wdata`: bits can go from 1 to 0 but never from 0 to 1. Other words are unchanged.
- R5: An erase sets every word of the sector holding `addr` to all ones. A sector is the group of `2**SECT_W` words that share `addr[ADDR_W-1:SECT_W]`. Words in other sectors are unchanged.
- R6: If a strobe falls while any other strobe is low (including two falling together), nothing is accepted. `busy_n` stays high and the array is untouched.
- R7: With `READ_ONLY=1`, program and erase strobes are ignored: `busy_n` stays high and the array keeps its contents. Reads work as in R1 to R3.
- R8: `osc_en` is 1 from reset onward, whatever the strobes do.
- R9: After reset, `busy_n`=1, `rd_valid`=0, `rdata`=0, and every array word reads as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req_n | input | 1 | Read request strobe, active low |
| wr_req_n | input | 1 | Program request strobe, active low |
| er_req_n | input | 1 | Sector erase request strobe, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Program data |
| rdata | output | DATA_W | Word from the last completed read |
| rd_valid | output | 1 | High after a read completes, until the next accepted request |
| busy_n | output | 1 | Low while an operation runs |
| osc_en | output | 1 | Oscillator enable, held at 1 |

## Verification
Reads are tried on an erased word and on words after one and two programs. This separates a true AND-into-word program from a plain overwrite, and shows that the read latency differs from the program latency. Erases are tried on a sector holding programmed words with a programmed neighbour in the next sector, which catches a sector mask that is too wide or too narrow. The handshake is checked with strobes held past completion, a strobe pulsed during busy, and two strobes falling together: each of these must leave `busy_n` high. A second, read-only instance shares the same stimulus, so a program or erase that the full instance carries out is shown to be ignored by the read-only one.

// File: rtl/nvm_par_pkg.sv
package nvm_par_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_PROG,
        ST_ERASE
    } nvm_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_PROG,
        OP_ERASE
    } nvm_op_t;

    // strobe vector bit positions
    localparam int STB_RD = 0;
    localparam int STB_WR = 1;
    localparam int STB_ER = 2;
    localparam int STB_N  = 3;

endpackage

// File: rtl/nvm_req_edge.sv
module nvm_req_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] low
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= strobe_n;
    end

    assign low  = ~strobe_n;
    assign fall = prev_q & ~strobe_n;

    // R1: a held-low strobe reports its fall once only
    a_r1_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall) |=> ((fall & $past(fall)) == '0));

endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SEC_AW = ADDR_W - SECT_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [SEC_AW-1:0] sel_sector;

    assign sel_sector = addr[ADDR_W-1:SECT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (erase_en && (SEC_AW'(i >> SECT_W) == sel_sector))
                    mem[i] <= '1;
                else if (prog_en && (ADDR_W'(i) == addr))
                    mem[i] <= mem[i] & wdata;
            end
        end
    end

    assign rd_word = mem[addr];

    // R4: a program never raises a bit
    a_r4_prog_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> ((mem[$past(addr)] & ~$past(rd_word)) == '0));

    // R5: the erased address reads all ones afterwards
    a_r5_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (mem[$past(addr)] == '1));

endmodule

// File: rtl/nvm_op_seq.sv
module nvm_op_seq
    import nvm_par_pkg::*;
#(
    parameter int READ_CYC  = 2,
    parameter int PROG_CYC  = 5,
    parameter int ERASE_CYC = 12,
    parameter bit READ_ONLY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STB_N-1:0] fall,
    input  logic [STB_N-1:0] low,
    output logic             accept,
    output logic             prog_en,
    output logic             erase_en,
    output logic             rd_done,
    output logic             busy_n,
    output logic             rd_valid
);
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC)
                           ? ((ERASE_CYC > READ_CYC) ? ERASE_CYC : READ_CYC)
                           : ((PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC);
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    nvm_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    nvm_op_t          req_op;
    logic             legal, done;

    // exactly one strobe fell and no other is low
    assign legal = $onehot(fall) && (low == fall);

    always_comb begin
        req_op = OP_NONE;
        if (legal) begin
            if (fall[STB_RD])                   req_op = OP_READ;
            else if (fall[STB_WR] && !READ_ONLY) req_op = OP_PROG;
            else if (fall[STB_ER] && !READ_ONLY) req_op = OP_ERASE;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                unique case (req_op)
                    OP_READ:  begin state_d = ST_READ;  cnt_d = CNT_W'(READ_CYC - 1);  end
                    OP_PROG:  begin state_d = ST_PROG;  cnt_d = CNT_W'(PROG_CYC - 1);  end
                    OP_ERASE: begin state_d = ST_ERASE; cnt_d = CNT_W'(ERASE_CYC - 1); end
                    OP_NONE:  ;
                endcase
            end
            ST_READ, ST_PROG, ST_ERASE: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                    done    = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign accept   = (state_q == ST_IDLE) && (req_op != OP_NONE);
    assign prog_en  = done && (state_q == ST_PROG);
    assign erase_en = done && (state_q == ST_ERASE);
    assign rd_done  = done && (state_q == ST_READ);

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_n   <= 1'b1;
            rd_valid <= 1'b0;
        end else if (accept) begin
            busy_n   <= 1'b0;
            rd_valid <= 1'b0;
        end else if (done) begin
            busy_n   <= 1'b1;
            rd_valid <= rd_done;
        end
    end

    // R2: busy flag low whenever an operation is in flight
    a_r2_busy_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !busy_n);

    // R3: an accepted request clears the read-valid flag
    a_r3_valid_clear: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !rd_valid);

    // R6: conflicting strobes in idle start nothing
    a_r6_conflict_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && ($countones(low) > 1)) |=> busy_n);

    // R7: a read-only build never programs or erases
    a_r7_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        READ_ONLY |-> (!prog_en && !erase_en));

endmodule

// File: rtl/nvm_par_ctrl.sv
module nvm_par_ctrl
    import nvm_par_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int SECT_W    = 3,
    parameter int READ_CYC  = 2,
    parameter int PROG_CYC  = 5,
    parameter int ERASE_CYC = 12,
    parameter bit READ_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_n,
    input  logic              wr_req_n,
    input  logic              er_req_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              busy_n,
    output logic              osc_en
);
    logic [STB_N-1:0]  strobe_n, fall, low;
    logic              accept, prog_en, erase_en, rd_done;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rd_word;

    always_comb begin
        strobe_n         = '1;
        strobe_n[STB_RD] = rd_req_n;
        strobe_n[STB_WR] = wr_req_n;
        strobe_n[STB_ER] = er_req_n;
    end

    nvm_req_edge #(.N(STB_N)) u_edge (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .fall(fall), .low(low)
    );

    nvm_op_seq #(
        .READ_CYC(READ_CYC), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .READ_ONLY(READ_ONLY)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .fall(fall), .low(low),
        .accept(accept), .prog_en(prog_en), .erase_en(erase_en),
        .rd_done(rd_done), .busy_n(busy_n), .rd_valid(rd_valid)
    );

    // request operands are held for the whole operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    nvm_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_array (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .erase_en(erase_en),
        .addr(addr_q), .wdata(wdata_q), .rd_word(rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata <= '0;
        else if (rd_done) rdata <= rd_word;
    end

    assign osc_en = 1'b1;

    // R3: read data only changes when a read finishes
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> (rd_valid || $stable(rdata)));

endmodule

// File: tb/nvm_par_ctrl_tb.sv
module nvm_par_ctrl_tb;
    localparam int AW = 6, DW = 16, SW = 3;
    localparam int RC = 2, PC = 5, EC = 12;
    localparam int K_RD = 0, K_WR = 1, K_ER = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_req_n = 1'b1, wr_req_n = 1'b1, er_req_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata, ro_rdata;
    logic rd_valid, busy_n, osc_en, ro_valid, ro_busy_n, ro_osc;

    int n_chk = 0, n_err = 0;
    bit ro_seen = 1'b0;

    always #5 clk = ~clk;

    nvm_par_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW), .READ_CYC(RC),
                   .PROG_CYC(PC), .ERASE_CYC(EC), .READ_ONLY(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_req_n(rd_req_n), .wr_req_n(wr_req_n),
        .er_req_n(er_req_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rd_valid(rd_valid), .busy_n(busy_n), .osc_en(osc_en));

    nvm_par_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW), .READ_CYC(RC),
                   .PROG_CYC(PC), .ERASE_CYC(EC), .READ_ONLY(1'b1)) u_dut_ro (
        .clk(clk), .rst_n(rst_n), .rd_req_n(rd_req_n), .wr_req_n(wr_req_n),
        .er_req_n(er_req_n), .addr(addr), .wdata(wdata), .rdata(ro_rdata),
        .rd_valid(ro_valid), .busy_n(ro_busy_n), .osc_en(ro_osc));

    always @(negedge clk) if (rst_n && !ro_busy_n) ro_seen = 1'b1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic release_all();
        rd_req_n = 1'b1; wr_req_n = 1'b1; er_req_n = 1'b1;
    endtask

    // one operation: strobe falls, busy length measured, strobe held past the end
    task automatic run_op(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d, output int lat);
        @(negedge clk);
        addr = a; wdata = d;
        if (kind == K_RD) rd_req_n = 1'b0;
        else if (kind == K_WR) wr_req_n = 1'b0;
        else er_req_n = 1'b0;
        @(negedge clk);
        lat = 0;
        while (!busy_n && lat < 100) begin
            lat++;
            @(negedge clk);
        end
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(busy_n, "R1 held strobe must not retrigger", {31'b0, busy_n}, 1);
        end
        release_all();
        @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        int lat;
        run_op(K_RD, a, '0, lat);
        chk(lat == RC, "R2 read busy length", lat, RC);
        chk(rd_valid, "R3 valid after read", {31'b0, rd_valid}, 1);
        chk(rdata == exp, tag, rdata, exp);
    endtask

    task automatic do_prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lat;
        run_op(K_WR, a, d, lat);
        chk(lat == PC, "R2 program busy length", lat, PC);
    endtask

    task automatic t_reset();
        chk(busy_n == 1'b1, "R9 busy_n after reset", {31'b0, busy_n}, 1);
        chk(rd_valid == 1'b0, "R9 rd_valid after reset", {31'b0, rd_valid}, 0);
        chk(rdata == '0, "R9 rdata after reset", rdata, 0);
        chk(osc_en == 1'b1 && ro_osc == 1'b1, "R8 osc_en after reset", {30'b0, osc_en, ro_osc}, 3);
        do_read(6'd5, 16'hFFFF, "R9 array erased after reset");
    endtask

    task automatic t_program();
        int lat;
        do_prog(6'd5, 16'hA5F0);
        chk(!rd_valid, "R3 valid cleared by next request", {31'b0, rd_valid}, 0);
        do_read(6'd5, 16'hA5F0, "R4 first program");
        do_prog(6'd5, 16'h0FFF);
        do_read(6'd5, 16'h05F0, "R4 program only clears bits");
        do_read(6'd6, 16'hFFFF, "R4 neighbour word unchanged");
        // valid must drop on the very edge a new request is taken
        @(negedge clk); wr_req_n = 1'b0; addr = 6'd7; wdata = 16'hFFFF;
        @(negedge clk);
        chk(!rd_valid && !busy_n, "R3 valid cleared with busy fall", {30'b0, rd_valid, busy_n}, 0);
        while (!busy_n) @(negedge clk);
        release_all();
        @(negedge clk);
        lat = 0;
    endtask

    task automatic t_erase();
        int lat;
        do_prog(6'd9, 16'h1234);
        do_prog(6'd14, 16'h0000);
        do_prog(6'd16, 16'h4321);
        run_op(K_ER, 6'd10, '0, lat);
        chk(lat == EC, "R2 erase busy length", lat, EC);
        do_read(6'd9, 16'hFFFF, "R5 sector word 9 erased");
        do_read(6'd14, 16'hFFFF, "R5 sector word 14 erased");
        do_read(6'd16, 16'h4321, "R5 next sector kept");
        do_read(6'd5, 16'h05F0, "R5 lower sector kept");
    endtask

    task automatic t_conflict();
        @(negedge clk); addr = 6'd16; wdata = 16'h0000;
        rd_req_n = 1'b0; wr_req_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(busy_n, "R6 read+program together ignored", {31'b0, busy_n}, 1);
        end
        release_all();
        @(negedge clk); addr = 6'd17; wr_req_n = 1'b0; er_req_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(busy_n, "R6 program+erase together ignored", {31'b0, busy_n}, 1);
        end
        release_all();
        // fall while another strobe already held low
        @(negedge clk); addr = 6'd16; er_req_n = 1'b0;
        @(negedge clk); er_req_n = 1'b1;
        while (!busy_n) @(negedge clk);
        @(negedge clk);
        do_read(6'd16, 16'hFFFF, "R6 setup erase of sector 2");
        do_prog(6'd16, 16'h00FF);
        @(negedge clk); addr = 6'd16; rd_req_n = 1'b0; wdata = 16'h0000;
        @(negedge clk); // read accepted here
        while (!busy_n) @(negedge clk);
        wr_req_n = 1'b0; // falls while read strobe still low
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(busy_n, "R6 program fall while read held ignored", {31'b0, busy_n}, 1);
        end
        release_all();
        @(negedge clk);
        do_read(6'd16, 16'h00FF, "R6 array untouched by conflicts");
    endtask

    task automatic t_busy_ignore();
        @(negedge clk); addr = 6'd20; er_req_n = 1'b0;
        @(negedge clk);
        chk(!busy_n, "R2 erase started", {31'b0, busy_n}, 0);
        @(negedge clk); er_req_n = 1'b1;
        @(negedge clk); rd_req_n = 1'b0; addr = 6'd5;
        while (!busy_n) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(busy_n, "R2 strobe during busy not remembered", {31'b0, busy_n}, 1);
        end
        chk(!rd_valid, "R2 no read ran after busy", {31'b0, rd_valid}, 0);
        release_all();
        @(negedge clk);
    endtask

    task automatic t_read_only();
        int lat;
        ro_seen = 1'b0;
        run_op(K_WR, 6'd3, 16'h0000, lat);
        chk(!ro_seen, "R7 read-only ignores program", {31'b0, ro_seen}, 0);
        do_read(6'd3, 16'h0000, "R4 full instance programmed word 3");
        chk(ro_rdata == 16'hFFFF && ro_valid, "R7 read-only word 3 unchanged", ro_rdata, 16'hFFFF);
        ro_seen = 1'b0;
        run_op(K_ER, 6'd3, '0, lat);
        chk(!ro_seen, "R7 read-only ignores erase", {31'b0, ro_seen}, 0);
        chk(osc_en && ro_osc, "R8 osc_en still high", {30'b0, osc_en, ro_osc}, 3);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase();
        t_conflict();
        t_busy_ignore();
        t_read_only();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule